// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in in pure combinational logic and returns a 16-bit sum and a carry-out. No carry ripples from bit to bit. The operands are cut into four identical 4-bit groups. Each group forms a propagate term (the two bits differ) and a generate term (both bits set) for every bit position. From those terms it forms each of its internal carries directly as a sum of products. It also reduces them to one group propagate and one group generate.

A second lookahead level takes the four group terms and the carry-in. It forms the carries entering bit positions 4, 8 and 12 and the final carry into position 16, using the same flat sum-of-products form one level up. It also exports a block-wide propagate and generate pair. A larger adder can nest this pair in a further level in the same way. The block sits in a datapath wherever an add must settle within a small number of logic levels.

Top module: `hcla_adder`

## Requirements
- R1: For every bit position, the propagate term is a XOR b and the generate term is a AND b. Neither term depends on any carry, so the two are never 1 together.
- R2: Inside a 4-bit group, the carry into bit i+1 equals g_i OR (p_i AND c_i). Each carry is formed as a flat sum of products over the group's terms and the group carry-in, not taken from the carry of the bit below.
- R3: Each group's propagate is the AND of its four bit propagates. Its generate is g3 | p3g2 | p3p2g1 | p3p2p1g0. The two are never 1 together.
- R4: The second level forms the carries into bits 4, 8 and 12 and the carry-out into bit 16 from the group terms and `carry_in` alone. Each such carry equals G_j OR (P_j AND the carry into group j).
- R5: Bit i of `sum_o` is 1 exactly when an odd number of a_i, b_i and the carry into bit i are 1.
- R6: {`carry_o`, `sum_o`} equals `op_a` + `op_b` + `carry_in` as an ordinary 17-bit unsigned sum, for every input combination.
- R7: `blk_prop_o` is 1 exactly when `op_a` and `op_b` differ in every bit position. `blk_gen_o` is 1 exactly when `op_a` + `op_b` with a carry-in of 0 exceeds 16'hFFFF. Neither depends on `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the sum |
| carry_o | output | 1 | Carry out of bit 15 |
| blk_prop_o | output | 1 | Block-wide propagate term |
| blk_gen_o | output | 1 | Block-wide generate term |

## Verification
Every 4-bit group is driven through all 512 combinations of its two nibbles and its incoming carry. For groups above the lowest, the incoming carry is made by a generating bit pair just below the group. A wrong product term inside any group's lookahead therefore shows up in that group alone. All-ones plus one, and complementary patterns with the carry-in toggled, force a carry to travel the full 16 bits through both lookahead levels. These patterns also separate the block propagate from the block generate. All zeros, alternating bit patterns and random vectors cover the ordinary sums, where carries stop part of the way.

// File: rtl/hcla_pkg.sv
package hcla_pkg;

    // Propagate/generate pair carried through both lookahead levels
    typedef struct packed {
        logic prop;
        logic gen;
    } pg_t;

    // Per-bit terms: these depend on the operand bits only
    function automatic pg_t bit_pg(input logic a, input logic b);
        pg_t r;
        r.prop = a ^ b;
        r.gen  = a & b;
        return r;
    endfunction

    // Associative combine of an upper span over a lower span
    function automatic pg_t span_merge(input pg_t hi, input pg_t lo);
        pg_t r;
        r.prop = hi.prop & lo.prop;
        r.gen  = hi.gen | (hi.prop & lo.gen);
        return r;
    endfunction

endpackage

// File: rtl/hcla_lookahead.sv
module hcla_lookahead
    import hcla_pkg::*;
#(
    parameter int N = 4
) (
    input  pg_t [N-1:0]  pg_i,
    input  logic         cin_i,
    output logic [N-1:0] carry_o,   // carry into each position, carry_o[0] = cin_i
    output pg_t          span_o
);

    // Each carry as a flat sum of products: no carry feeds another carry
    always_comb begin
        logic acc;
        logic term;
        carry_o[0] = cin_i;
        for (int j = 1; j < N; j++) begin
            acc = 1'b0;
            for (int k = 0; k < j; k++) begin
                term = pg_i[k].gen;
                for (int m = k + 1; m < j; m++) begin
                    term = term & pg_i[m].prop;
                end
                acc = acc | term;
            end
            term = cin_i;
            for (int m = 0; m < j; m++) begin
                term = term & pg_i[m].prop;
            end
            carry_o[j] = acc | term;
        end
    end

    // Span terms, again in flat form
    always_comb begin
        logic acc;
        logic term;
        logic pall;
        acc  = 1'b0;
        pall = 1'b1;
        for (int k = 0; k < N; k++) begin
            term = pg_i[k].gen;
            for (int m = k + 1; m < N; m++) begin
                term = term & pg_i[m].prop;
            end
            acc  = acc | term;
            pall = pall & pg_i[k].prop;
        end
        span_o.prop = pall;
        span_o.gen  = acc;
    end

    // Checks against the bit-serial recurrence and a folded merge
    generate
        for (genvar j = 0; j < N - 1; j++) begin : g_rec_chk
            always_comb begin
                if (!$isunknown({pg_i, cin_i})) begin
                    AST_CARRY_RECUR: assert (carry_o[j+1] ==
                        (pg_i[j].gen | (pg_i[j].prop & carry_o[j])))
                        else $error("carry recurrence broken at %0d", j+1); // R2
                end
            end
        end
    endgenerate

    always_comb begin
        pg_t fold;
        fold = pg_i[0];
        for (int k = 1; k < N; k++) begin
            fold = span_merge(pg_i[k], fold);
        end
        if (!$isunknown(pg_i)) begin
            AST_SPAN_FOLD: assert (fold == span_o)
                else $error("span terms disagree with folded merge"); // R3
        end
    end

endmodule

// File: rtl/hcla_group.sv
module hcla_group
    import hcla_pkg::*;
#(
    parameter int GRP_W = 4
) (
    input  logic [GRP_W-1:0] a_i,
    input  logic [GRP_W-1:0] b_i,
    input  logic             cin_i,
    output logic [GRP_W-1:0] sum_o,
    output pg_t              grp_o
);

    pg_t  [GRP_W-1:0] bit_terms;
    logic [GRP_W-1:0] bit_carry;

    generate
        for (genvar i = 0; i < GRP_W; i++) begin : g_bit
            assign bit_terms[i] = bit_pg(a_i[i], b_i[i]);
            assign sum_o[i]     = bit_terms[i].prop ^ bit_carry[i];

            always_comb begin
                if (!$isunknown({a_i[i], b_i[i]})) begin
                    AST_PG_EXCL: assert (!(bit_terms[i].prop && bit_terms[i].gen))
                        else $error("bit %0d propagate and generate both set", i); // R1
                end
            end
        end
    endgenerate

    hcla_lookahead #(
        .N (GRP_W)
    ) u_la (
        .pg_i    (bit_terms),
        .cin_i   (cin_i),
        .carry_o (bit_carry),
        .span_o  (grp_o)
    );

    always_comb begin
        logic [GRP_W:0] ref_sum;
        ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{GRP_W{1'b0}}, cin_i};
        if (!$isunknown({a_i, b_i, cin_i})) begin
            AST_GROUP_SUM: assert (sum_o == ref_sum[GRP_W-1:0])
                else $error("group sum wrong"); // R5
            AST_GROUP_EXCL: assert (!(grp_o.prop && grp_o.gen))
                else $error("group propagate and generate both set"); // R3
        end
    end

endmodule

// File: rtl/hcla_upper.sv
module hcla_upper
    import hcla_pkg::*;
#(
    parameter int NGRP = 4
) (
    input  pg_t [NGRP-1:0]  grp_i,
    input  logic            cin_i,
    output logic [NGRP-1:0] grp_cin_o,   // carry entering each group
    output logic            cout_o,
    output pg_t             blk_o
);

    hcla_lookahead #(
        .N (NGRP)
    ) u_la (
        .pg_i    (grp_i),
        .cin_i   (cin_i),
        .carry_o (grp_cin_o),
        .span_o  (blk_o)
    );

    // Final carry from the block-wide terms, not from the last group carry
    assign cout_o = blk_o.gen | (blk_o.prop & cin_i);

    always_comb begin
        if (!$isunknown({grp_i, cin_i})) begin
            AST_TOP_CARRY: assert (cout_o ==
                (grp_i[NGRP-1].gen | (grp_i[NGRP-1].prop & grp_cin_o[NGRP-1])))
                else $error("carry-out disagrees with last group"); // R4
            AST_BLK_EXCL: assert (!(blk_o.prop && blk_o.gen))
                else $error("block propagate and generate both set"); // R7
        end
    end

endmodule

// File: rtl/hcla_adder.sv
module hcla_adder
    import hcla_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int GRP_W  = 4
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              blk_prop_o,
    output logic              blk_gen_o
);

    localparam int NGRP = DATA_W / GRP_W;

    pg_t  [NGRP-1:0] grp_terms;
    logic [NGRP-1:0] grp_cin;
    pg_t             blk_terms;

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            hcla_group #(
                .GRP_W (GRP_W)
            ) u_grp (
                .a_i   (op_a[g*GRP_W +: GRP_W]),
                .b_i   (op_b[g*GRP_W +: GRP_W]),
                .cin_i (grp_cin[g]),
                .sum_o (sum_o[g*GRP_W +: GRP_W]),
                .grp_o (grp_terms[g])
            );
        end
    endgenerate

    hcla_upper #(
        .NGRP (NGRP)
    ) u_upper (
        .grp_i     (grp_terms),
        .cin_i     (carry_in),
        .grp_cin_o (grp_cin),
        .cout_o    (carry_o),
        .blk_o     (blk_terms)
    );

    assign blk_prop_o = blk_terms.prop;
    assign blk_gen_o  = blk_terms.gen;

    always_comb begin
        logic [DATA_W:0] ref_total;
        ref_total = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, carry_in};
        if (!$isunknown({op_a, op_b, carry_in})) begin
            AST_TOTAL_SUM: assert ({carry_o, sum_o} == ref_total)
                else $error("17-bit result wrong"); // R6
        end
    end

endmodule

// File: tb/hcla_adder_tb_top.sv
module hcla_adder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int GW         = 4;
    localparam int NG         = W / GW;
    localparam int WDOG_LIMIT = 150000;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_o;
    logic         carry_o;
    logic         blk_prop_o;
    logic         blk_gen_o;

    int  n_checks = 0;
    int  n_bad    = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hcla_adder #(
        .DATA_W (W),
        .GRP_W  (GW)
    ) dut_i (
        .op_a       (op_a),
        .op_b       (op_b),
        .carry_in   (carry_in),
        .sum_o      (sum_o),
        .carry_o    (carry_o),
        .blk_prop_o (blk_prop_o),
        .blk_gen_o  (blk_gen_o)
    );

    // Drive at a falling edge, sample a little later
    task automatic apply_check(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic c, input string req);
        logic [W:0] exp_total;
        logic [W:0] exp_nocin;
        logic       exp_prop;
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        carry_in = c;
        #1;
        exp_total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        exp_nocin = {1'b0, a} + {1'b0, b};
        exp_prop  = &(a ^ b);
        n_checks++;
        if ({carry_o, sum_o} !== exp_total) begin
            n_bad++;
            $display("FAIL %s R6 a=%h b=%h c=%b: got %h expected %h",
                     req, a, b, c, {carry_o, sum_o}, exp_total);
        end
        n_checks++;
        if (blk_prop_o !== exp_prop || blk_gen_o !== exp_nocin[W]) begin
            n_bad++;
            $display("FAIL %s R7 a=%h b=%h c=%b: got p=%b g=%b expected p=%b g=%b",
                     req, a, b, c, blk_prop_o, blk_gen_o, exp_prop, exp_nocin[W]);
        end
    endtask

    task automatic t_zero();
        apply_check('0, '0, 1'b0, "R6 zero");
        apply_check('0, '0, 1'b1, "R5 zero+cin");
    endtask

    // Every group through all nibble pairs and incoming carries (R2, R3, R5)
    task automatic t_group_exhaustive();
        for (int g = 0; g < NG; g++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    for (int c = 0; c < 2; c++) begin
                        logic [W-1:0] a;
                        logic [W-1:0] b;
                        logic         ci;
                        a  = W'(x) << (g*GW);
                        b  = W'(y) << (g*GW);
                        ci = 1'b0;
                        if (g == 0) ci = c[0];
                        else if (c != 0) begin
                            a[g*GW-1] = 1'b1;
                            b[g*GW-1] = 1'b1;
                        end
                        apply_check(a, b, ci, "R2 group exhaustive");
                    end
                end
            end
        end
    endtask

    // Full-length carry through both lookahead levels (R4)
    task automatic t_long_carry();
        apply_check(16'hFFFF, 16'h0001, 1'b0, "R4 ones+1");
        apply_check(16'hFFFF, 16'h0000, 1'b1, "R4 ones+cin");
        apply_check(16'hA5C3, 16'h5A3C, 1'b1, "R4 complement+cin");
        apply_check(16'hA5C3, 16'h5A3C, 1'b0, "R7 complement no cin");
        apply_check(16'hFFFF, 16'hFFFF, 1'b1, "R4 max+max+cin");
        apply_check(16'h8000, 16'h8000, 1'b0, "R7 top generate");
    endtask

    task automatic t_alternating();
        apply_check(16'hAAAA, 16'h5555, 1'b0, "R1 alt differ");
        apply_check(16'hAAAA, 16'hAAAA, 1'b0, "R1 alt equal");
        apply_check(16'h5555, 16'h5555, 1'b1, "R5 alt equal+cin");
        apply_check(16'hF0F0, 16'h0F0F, 1'b1, "R4 nibble alt+cin");
        apply_check(16'h00FF, 16'h0001, 1'b0, "R4 byte carry");
    endtask

    task automatic t_random();
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = W'($urandom);
            b = W'($urandom);
            apply_check(a, b, 1'($urandom), "R6 random");
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_zero();
        t_group_exhaustive();
        t_long_carry();
        t_alternating();
        t_random();
        finish_run();
    end

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog R6: got timeout expected completion");
        finish_run();
    end

endmodule